// File: doc/BRIEF.md
# Stepper micro-step phase sequencer

This block sequences the four coil-drive levels of a two-coil stepper motor through an eight-phase electrical cycle. The cycle is subdivided into fine position units of 1/64 phase, so one full cycle is 512 units. On a start, the sequencer loads a programmed starting phase. Each step-rate tick then moves the position forward or backward by one micro-step, and the position wraps modulo eight phases in either direction. The programmed subdivision and the phase-advance mode set the size of that micro-step. Each coil has a positive-side and a negative-side drive output. In micro-step mode those outputs carry a duty level that follows a quarter-wave approximation of a sine. In square mode they carry plain full-on or full-off levels.

Configuration is captured when a run starts. A run lasts a programmed number of phase operations. When the last one completes, the block pulses `done_o` and holds its outputs until the enable is lowered. A run length of zero makes the block run without end. Lowering the enable during a run pauses stepping and freezes the outputs. Raising it again starts a new run from the starting phase.

Top module: `ustep_seq`

## Requirements
- R1: After reset, all four coil outputs are 0, `phase_o` is 0, and `busy_o` and `done_o` are 0.
- R2: When `en_i` is high while the block is idle, the next clock edge loads position = `start_phase_i`×64 and raises `busy_o`. All configuration inputs are captured at that edge, and later changes to them have no effect on the run.
- R3: Each clock edge with `busy_o`=1 and `tick_i`=1 moves the position by a stride. The stride is 64/N units when `dbl_i`=0, and twice that when `dbl_i`=1. Direction is increasing when `rev_i`=0 and decreasing when `rev_i`=1, and the position wraps modulo 512. `phase_o` = floor(position/64).
- R4: `sub_sel_i` selects N micro-steps per phase operation: 0→8, 1→16, 2→32, 3→64. One phase operation is complete after N ticks.
- R5: In micro-step mode the coil outputs are derived from a coil angle v, as follows.
  - Quadrant q = floor(v/128) and remainder r = v mod 128. Take k = r when q is even, and k = 128−r when q is odd.
  - The level is floor(255·k·(256−k)/16384) for the default 8-bit duty.
  - When q<2 the level goes on the positive output and the negative output is 0. When q≥2 it goes on the negative output and the positive output is 0.
- R6: Coil B uses v = position, and coil A uses v = position+128 mod 512. Coil A therefore leads coil B by two phases.
- R7: With `square_i`=1, a coil's positive output is 255 when floor(v/64) is 1, 2 or 3, and 0 otherwise. Its negative output is 255 when floor(v/64) is 5, 6 or 7, and 0 otherwise.
- R8: With `thr_en_i`=1 in micro-step mode, any level below min(`thr_i`, 99) is output as 0.
- R9: When the phase-operation count reaches a nonzero `run_len_i`, `done_o` is high for exactly one cycle and `busy_o` falls. The outputs then hold, and ticks are ignored until `en_i` goes low.
- R10: With `run_len_i`=0 the run never ends and `done_o` stays 0.
- R11: Lowering `en_i` during a run drops `busy_o` at the next edge and freezes the outputs, and ticks are then ignored. Raising `en_i` again starts a fresh run at the starting phase.
- R12: Ticks while idle have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable (start on high while idle, pause on low) |
| tick_i | input | 1 | Step-rate tick, one micro-step per high cycle |
| start_phase_i | input | 3 | Starting phase 0..7 |
| rev_i | input | 1 | 0 = increasing phase order, 1 = decreasing |
| sub_sel_i | input | 2 | Micro-steps per phase: 0=8, 1=16, 2=32, 3=64 |
| dbl_i | input | 1 | 0 = one phase per operation, 1 = two phases per operation |
| square_i | input | 1 | Square-wave coil levels instead of micro-step levels |
| thr_en_i | input | 1 | Enable small-level suppression |
| thr_i | input | 7 | Suppression threshold, capped at 99 |
| run_len_i | input | RUN_W | Phase operations per run, 0 = endless |
| coil_ap_o | output | DUTY_W | Coil A positive-side duty |
| coil_an_o | output | DUTY_W | Coil A negative-side duty |
| coil_bp_o | output | DUTY_W | Coil B positive-side duty |
| coil_bn_o | output | DUTY_W | Coil B negative-side duty |
| phase_o | output | 3 | Current phase index |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse at end of run |

## Verification
The outputs are combinational from the position register and the captured configuration, so a wrong stride or direction appears on the coil outputs in the cycle after the offending tick. A wrong micro-step counter or step counter is slower to appear. It shows up as `done_o` firing early or late relative to the run length times the subdivision, and only at the end of a run. For that reason every sweep runs two full phase operations and checks the done cycle exactly. A fault in the quadrant folding or the coil offset appears as a mismatched level or a wrong positive/negative side within the first quarter cycle.

// File: rtl/ustep_pkg.sv
package ustep_pkg;
  localparam int PHASE_W = 3;
  localparam int THR_W   = 7;
  localparam int THR_CAP = 99;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_HOLD = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic             rev;
    logic [1:0]       sub_sel;
    logic             dbl;
    logic             square;
    logic             thr_en;
    logic [THR_W-1:0] thr;
  } run_cfg_t;
endpackage

// File: rtl/ustep_ctrl.sv
module ustep_ctrl
  import ustep_pkg::*;
#(
  parameter int FINE_W = 6,
  parameter int RUN_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             tick_i,
  input  run_cfg_t         cfg_i,
  input  logic [RUN_W-1:0] run_len_i,
  output run_cfg_t         cfg_o,
  output logic             load_o,
  output logic             adv_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             live_o
);
  localparam int BASE_SH = FINE_W - 3;
  localparam logic [FINE_W-1:0] ALL1  = '1;
  localparam logic [FINE_W-1:0] ONE_F = {{(FINE_W-1){1'b0}}, 1'b1};
  localparam logic [RUN_W-1:0]  ONE_R = {{(RUN_W-1){1'b0}}, 1'b1};

  seq_state_e       state_q, state_d;
  logic [FINE_W-1:0] micro_q, micro_d, micro_last;
  logic [RUN_W-1:0]  steps_q, steps_d, steps_inc;
  logic [RUN_W-1:0]  len_q, len_d;
  run_cfg_t          cfg_q, cfg_d;
  logic              live_q, live_d;
  logic              done_q, done_d;
  logic              load, adv;

  always_comb begin
    micro_last = ~((ALL1 << BASE_SH) << cfg_q.sub_sel);
    steps_inc  = steps_q + ONE_R;
    state_d    = state_q;
    micro_d    = micro_q;
    steps_d    = steps_q;
    len_d      = len_q;
    cfg_d      = cfg_q;
    live_d     = live_q;
    done_d     = 1'b0;
    load       = 1'b0;
    adv        = 1'b0;
    case (state_q)
      SEQ_IDLE: begin
        if (en_i) begin
          state_d = SEQ_RUN;
          load    = 1'b1;
          micro_d = '0;
          steps_d = '0;
          cfg_d   = cfg_i;
          len_d   = run_len_i;
          live_d  = 1'b1;
        end
      end
      SEQ_RUN: begin
        if (!en_i) begin
          state_d = SEQ_IDLE;
        end else if (tick_i) begin
          adv = 1'b1;
          if (micro_q == micro_last) begin
            micro_d = '0;
            steps_d = steps_inc;
            if ((len_q != '0) && (steps_inc == len_q)) begin
              state_d = SEQ_HOLD;
              done_d  = 1'b1;
            end
          end else begin
            micro_d = micro_q + ONE_F;
          end
        end
      end
      SEQ_HOLD: begin
        if (!en_i) state_d = SEQ_IDLE;
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      micro_q <= '0;
      steps_q <= '0;
      len_q   <= '0;
      cfg_q   <= '0;
      live_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      micro_q <= micro_d;
      steps_q <= steps_d;
      len_q   <= len_d;
      cfg_q   <= cfg_d;
      live_q  <= live_d;
      done_q  <= done_d;
    end
  end

  assign cfg_o  = cfg_q;
  assign load_o = load;
  assign adv_o  = adv;
  assign busy_o = (state_q == SEQ_RUN);
  assign done_o = done_q;
  assign live_o = live_q;
endmodule

// File: rtl/ustep_posacc.sv
module ustep_posacc
  import ustep_pkg::*;
#(
  parameter int FINE_W = 6,
  localparam int POS_W = PHASE_W + FINE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic               adv_i,
  input  logic [PHASE_W-1:0] start_ph_i,
  input  logic               rev_i,
  input  logic [1:0]         sub_sel_i,
  input  logic               dbl_i,
  output logic [POS_W-1:0]   pos_o
);
  localparam int UNIT_SH = FINE_W - 3;
  localparam logic [POS_W-1:0] ONE_P = {{(POS_W-1){1'b0}}, 1'b1};

  logic [POS_W-1:0] pos_q, pos_d, unit, stride;

  always_comb begin
    unit   = (ONE_P << UNIT_SH) >> sub_sel_i;
    stride = dbl_i ? (unit << 1) : unit;
    if (load_i)
      pos_d = {start_ph_i, {FINE_W{1'b0}}};
    else if (rev_i)
      pos_d = pos_q - stride;
    else
      pos_d = pos_q + stride;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pos_q <= '0;
    else if (load_i || adv_i)
      pos_q <= pos_d;
  end

  assign pos_o = pos_q;
endmodule

// File: rtl/ustep_coil.sv
module ustep_coil
  import ustep_pkg::*;
#(
  parameter int          POS_W  = 9,
  parameter int          DUTY_W = 8,
  parameter int unsigned OFFSET = 0
) (
  input  logic [POS_W-1:0]  pos_i,
  input  logic              live_i,
  input  logic              square_i,
  input  logic              thr_en_i,
  input  logic [THR_W-1:0]  thr_i,
  output logic [DUTY_W-1:0] drv_p_o,
  output logic [DUTY_W-1:0] drv_n_o
);
  localparam int Q_W    = POS_W - 2;
  localparam int PROD_W = DUTY_W + 2 * Q_W + 2;
  localparam logic [POS_W-1:0]  OFS       = POS_W'(OFFSET);
  localparam logic [Q_W+1:0]    QUART     = (Q_W + 2)'(1) << Q_W;
  localparam logic [Q_W+1:0]    HALF_SPAN = (Q_W + 2)'(1) << (Q_W + 1);
  localparam logic [DUTY_W-1:0] DMAX      = '1;
  localparam logic [THR_W-1:0]  CAP       = THR_W'(THR_CAP);

  logic [POS_W-1:0]   v;
  logic [1:0]         quad;
  logic [Q_W-1:0]     rem;
  logic [PHASE_W-1:0] ph;
  logic [Q_W+1:0]     k;
  logic [PROD_W-1:0]  prod;
  logic [DUTY_W-1:0]  mag;
  logic [THR_W-1:0]   thr_eff;
  logic               sq_p, sq_n;

  always_comb begin
    v       = pos_i + OFS;
    quad    = v[POS_W-1 -: 2];
    rem     = v[Q_W-1:0];
    ph      = v[POS_W-1 -: PHASE_W];
    k       = quad[0] ? (QUART - {2'b00, rem}) : {2'b00, rem};
    prod    = PROD_W'(DMAX) * PROD_W'(k) * PROD_W'(HALF_SPAN - k);
    mag     = prod[2*Q_W +: DUTY_W];
    thr_eff = (thr_i > CAP) ? CAP : thr_i;
    if (thr_en_i && (mag < DUTY_W'(thr_eff))) mag = '0;
    sq_p = (ph == PHASE_W'(1)) || (ph == PHASE_W'(2)) || (ph == PHASE_W'(3));
    sq_n = (ph == PHASE_W'(5)) || (ph == PHASE_W'(6)) || (ph == PHASE_W'(7));
    if (!live_i) begin
      drv_p_o = '0;
      drv_n_o = '0;
    end else if (square_i) begin
      drv_p_o = sq_p ? DMAX : '0;
      drv_n_o = sq_n ? DMAX : '0;
    end else begin
      drv_p_o = quad[1] ? '0 : mag;
      drv_n_o = quad[1] ? mag : '0;
    end
  end
endmodule

// File: rtl/ustep_seq.sv
module ustep_seq
  import ustep_pkg::*;
#(
  parameter int DUTY_W = 8,
  parameter int RUN_W  = 16,
  parameter int FINE_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic               tick_i,
  input  logic [PHASE_W-1:0] start_phase_i,
  input  logic               rev_i,
  input  logic [1:0]         sub_sel_i,
  input  logic               dbl_i,
  input  logic               square_i,
  input  logic               thr_en_i,
  input  logic [THR_W-1:0]   thr_i,
  input  logic [RUN_W-1:0]   run_len_i,
  output logic [DUTY_W-1:0]  coil_ap_o,
  output logic [DUTY_W-1:0]  coil_an_o,
  output logic [DUTY_W-1:0]  coil_bp_o,
  output logic [DUTY_W-1:0]  coil_bn_o,
  output logic [PHASE_W-1:0] phase_o,
  output logic               busy_o,
  output logic               done_o
);
  localparam int POS_W = PHASE_W + FINE_W;
  localparam int unsigned QUART = 1 << (POS_W - 2);
  localparam int N_COIL = 2;

  logic [1:0]        rst_sync;
  logic              rst_n_s;
  run_cfg_t          cfg_in, cfg_q;
  logic              load, adv, live;
  logic [POS_W-1:0]  pos;
  logic [DUTY_W-1:0] drv_p [N_COIL];
  logic [DUTY_W-1:0] drv_n [N_COIL];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  always_comb begin
    cfg_in.rev     = rev_i;
    cfg_in.sub_sel = sub_sel_i;
    cfg_in.dbl     = dbl_i;
    cfg_in.square  = square_i;
    cfg_in.thr_en  = thr_en_i;
    cfg_in.thr     = thr_i;
  end

  ustep_ctrl #(.FINE_W(FINE_W), .RUN_W(RUN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n_s), .en_i(en_i), .tick_i(tick_i),
    .cfg_i(cfg_in), .run_len_i(run_len_i), .cfg_o(cfg_q),
    .load_o(load), .adv_o(adv), .busy_o(busy_o), .done_o(done_o),
    .live_o(live)
  );

  ustep_posacc #(.FINE_W(FINE_W)) u_pos (
    .clk(clk), .rst_n(rst_n_s), .load_i(load), .adv_i(adv),
    .start_ph_i(start_phase_i), .rev_i(cfg_q.rev),
    .sub_sel_i(cfg_q.sub_sel), .dbl_i(cfg_q.dbl), .pos_o(pos)
  );

  // index 0 = coil A (leads by two phases), index 1 = coil B
  for (genvar gi = 0; gi < N_COIL; gi++) begin : g_coil
    ustep_coil #(
      .POS_W(POS_W), .DUTY_W(DUTY_W),
      .OFFSET((gi == 0) ? QUART : 0)
    ) u_coil (
      .pos_i(pos), .live_i(live), .square_i(cfg_q.square),
      .thr_en_i(cfg_q.thr_en), .thr_i(cfg_q.thr),
      .drv_p_o(drv_p[gi]), .drv_n_o(drv_n[gi])
    );
  end

  assign coil_ap_o = drv_p[0];
  assign coil_an_o = drv_n[0];
  assign coil_bp_o = drv_p[1];
  assign coil_bn_o = drv_n[1];
  assign phase_o   = pos[POS_W-1 -: PHASE_W];
endmodule

// File: rtl/ustep_chk.sv
module ustep_chk #(
  parameter int DUTY_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_i,
  input logic              tick_i,
  input logic [2:0]        start_phase_i,
  input logic [DUTY_W-1:0] coil_ap_o,
  input logic [DUTY_W-1:0] coil_an_o,
  input logic [DUTY_W-1:0] coil_bp_o,
  input logic [DUTY_W-1:0] coil_bn_o,
  input logic [2:0]        phase_o,
  input logic              busy_o,
  input logic              done_o
);
  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9
  done_ends_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  // R5
  coil_a_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (coil_ap_o != '0) |-> (coil_an_o == '0));

  // R5
  coil_b_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (coil_bp_o != '0) |-> (coil_bn_o == '0));

  // R3
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && en_i && !tick_i) |=>
      $stable({phase_o, coil_ap_o, coil_an_o, coil_bp_o, coil_bn_o}));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !en_i) |=>
      $stable({phase_o, coil_ap_o, coil_an_o, coil_bp_o, coil_bn_o}));

  // R2
  start_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> ((phase_o == $past(start_phase_i)) || !$past(en_i)));
endmodule

bind ustep_seq ustep_chk #(.DUTY_W(DUTY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .tick_i(tick_i),
  .start_phase_i(start_phase_i),
  .coil_ap_o(coil_ap_o), .coil_an_o(coil_an_o),
  .coil_bp_o(coil_bp_o), .coil_bn_o(coil_bn_o),
  .phase_o(phase_o), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/sim_ustep_seq.sv
module sim_ustep_seq;
  localparam int CLK_P = 10;

  logic clk, rst_n, en, tick;
  logic [2:0] sp;
  logic rev, dbl, sq, te;
  logic [1:0] sel;
  logic [6:0] thr;
  logic [15:0] rlen;
  logic [7:0] ap, an, bp, bn;
  logic [2:0] ph;
  logic busy, done;

  int n_chk = 0;
  int n_bad = 0;
  int m_pos, m_S, m_micro, m_steps, m_len, m_th;
  bit m_live, m_busy, m_rev, m_dbl, m_sq, m_te;

  ustep_seq u0 (
    .clk(clk), .rst_n(rst_n), .en_i(en), .tick_i(tick),
    .start_phase_i(sp), .rev_i(rev), .sub_sel_i(sel), .dbl_i(dbl),
    .square_i(sq), .thr_en_i(te), .thr_i(thr), .run_len_i(rlen),
    .coil_ap_o(ap), .coil_an_o(an), .coil_bp_o(bp), .coil_bn_o(bn),
    .phase_o(ph), .busy_o(busy), .done_o(done)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int ref_lvl(int v, bit neg_side);
    int p, q, r, k, mag, thc;
    if (!m_live) return 0;
    p = v / 64;
    if (m_sq) begin
      if (neg_side) return (p >= 5) ? 255 : 0;
      return (p >= 1 && p <= 3) ? 255 : 0;
    end
    q = v / 128;
    r = v % 128;
    k = (q % 2 == 1) ? 128 - r : r;
    mag = (255 * k * (256 - k)) / 16384;
    thc = (m_th > 99) ? 99 : m_th;
    if (m_te && mag < thc) mag = 0;
    if ((q >= 2) != neg_side) return 0;
    return mag;
  endfunction

  task automatic check_outs(string req);
    int va;
    va = (m_pos + 128) % 512;
    chk(req, "coil_ap", int'(ap), ref_lvl(va, 1'b0));
    chk(req, "coil_an", int'(an), ref_lvl(va, 1'b1));
    chk(req, "coil_bp", int'(bp), ref_lvl(m_pos, 1'b0));
    chk(req, "coil_bn", int'(bn), ref_lvl(m_pos, 1'b1));
    chk(req, "phase",   int'(ph), m_pos / 64);
    chk(req, "busy",    int'(busy), int'(m_busy));
  endtask

  task automatic start_run(int s_ph, bit s_rev, int s_sel, bit s_dbl,
                           bit s_sq, bit s_te, int s_th, int s_len);
    sp = 3'(s_ph); rev = s_rev; sel = 2'(s_sel); dbl = s_dbl;
    sq = s_sq; te = s_te; thr = 7'(s_th); rlen = 16'(s_len);
    en = 1'b1;
    @(negedge clk);
    m_pos = s_ph * 64; m_rev = s_rev; m_S = 8 << s_sel; m_dbl = s_dbl;
    m_sq = s_sq; m_te = s_te; m_th = s_th; m_len = s_len;
    m_micro = 0; m_steps = 0; m_live = 1'b1; m_busy = 1'b1;
    check_outs("R2 start");
    chk("R2", "done", int'(done), 0);
  endtask

  task automatic tick_once(string req);
    int inc;
    bit exp_done;
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    exp_done = 1'b0;
    if (m_busy) begin
      inc = (64 / m_S) * (m_dbl ? 2 : 1);
      m_pos = m_rev ? (m_pos - inc + 512) % 512 : (m_pos + inc) % 512;
      m_micro++;
      if (m_micro == m_S) begin
        m_micro = 0;
        m_steps++;
        if (m_len != 0 && m_steps == m_len) begin
          exp_done = 1'b1;
          m_busy = 1'b0;
        end
      end
    end
    chk(req, "done", int'(done), int'(exp_done));
    check_outs(req);
  endtask

  task automatic stop_en(string req);
    en = 1'b0;
    @(negedge clk);
    m_busy = 1'b0;
    chk(req, "done", int'(done), 0);
    check_outs(req);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; tick = 1'b0; sp = '0; rev = 1'b0; sel = '0;
    dbl = 1'b0; sq = 1'b0; te = 1'b0; thr = '0; rlen = '0;
    m_pos = 0; m_live = 1'b0; m_busy = 1'b0; m_S = 8; m_micro = 0;
    m_steps = 0; m_len = 0; m_th = 0; m_rev = 1'b0; m_dbl = 1'b0;
    m_sq = 1'b0; m_te = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check_outs("R1");
    chk("R1", "done", int'(done), 0);

    // R12 ticks while idle
    tick_once("R12");
    tick_once("R12");

    // R3 R4 R5 R6 R9 sweep over every start phase, subdivision, mode, direction
    for (int s = 0; s < 4; s++)
      for (int d = 0; d < 2; d++)
        for (int r = 0; r < 2; r++)
          for (int p = 0; p < 8; p++) begin
            start_run(p, r[0], s, d[0], 1'b0, 1'b0, 0, 2);
            for (int t = 0; t < 2 * (8 << s); t++) tick_once("R3 R4 R5 R6 R9");
            tick_once("R9 hold");
            stop_en("R9 release");
          end

    // R7 square levels, reverse, two-phase advance
    start_run(6, 1'b1, 0, 1'b1, 1'b1, 1'b0, 0, 3);
    for (int t = 0; t < 24; t++) tick_once("R7");
    stop_en("R7");
    start_run(1, 1'b0, 1, 1'b0, 1'b1, 1'b0, 0, 8);
    for (int t = 0; t < 128; t++) tick_once("R7");
    stop_en("R7");

    // R8 threshold, capped and uncapped
    start_run(0, 1'b0, 3, 1'b0, 1'b0, 1'b1, 120, 2);
    for (int t = 0; t < 128; t++) tick_once("R8");
    stop_en("R8");
    start_run(7, 1'b1, 2, 1'b0, 1'b0, 1'b1, 30, 8);
    for (int t = 0; t < 256; t++) tick_once("R8");
    stop_en("R8");

    // R10 endless run
    start_run(3, 1'b0, 0, 1'b1, 1'b0, 1'b0, 0, 0);
    for (int t = 0; t < 300; t++) tick_once("R10");
    stop_en("R10");

    // R11 pause and restart
    start_run(1, 1'b0, 1, 1'b0, 1'b0, 1'b0, 0, 4);
    for (int t = 0; t < 10; t++) tick_once("R11");
    stop_en("R11 pause");
    tick_once("R11 ignored");
    tick_once("R11 ignored");
    start_run(1, 1'b0, 1, 1'b0, 1'b0, 1'b0, 0, 4);
    chk("R11", "restart phase", int'(ph), 1);
    for (int t = 0; t < 64; t++) tick_once("R11");
    stop_en("R11");

    // R2 configuration captured at start
    start_run(2, 1'b0, 1, 1'b0, 1'b0, 1'b0, 0, 3);
    rev = 1'b1; sel = 2'd3; dbl = 1'b1; sq = 1'b1; te = 1'b1; thr = 7'd90;
    rlen = 16'd1; sp = 3'd5;
    for (int t = 0; t < 48; t++) tick_once("R2 captured");
    stop_en("R2");

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule